// File: doc/BRIEF.md
# Output-Disable Request Flag Unit

This block watches a small group of active-low disable-request pins and keeps one sticky status flag per pin. Each pin has its own two-bit trigger field that picks one of two trigger types. The first is a falling edge on the synchronised pin. The second is a sustained low level, counted on one of three prescaled ticks derived from the peripheral clock. While any flag is set, the block holds a single request that tells the output drivers to go to high impedance.

Software reaches the block through a plain register port with two locations: the trigger-mode word and the flag word. A flag is cleared only in two steps. Software first reads the flag word and sees the bit as 1, then writes 0 to that bit. In level mode the clear is refused until the pin has been sampled high again at the selected tick rate. The port has no data stream: reads return data in the same cycle and writes take effect at the next clock edge, so there is no back-pressure to manage.

Top module: `odr_unit`

## Requirements
- R1: After reset all flags read 0, the mode word reads 0 (edge mode on every pin) and `hiz_req` is low.
- R2: The mode word (address 0) holds pin i's two-bit field at bits [2i+3:2i+2]. All other bits read 0, and the written field values read back unchanged.
- R3: With field value 00, a falling edge on a pin sets its flag within four clock cycles. Pins without a falling edge keep their flags at 0.
- R4: Field values 01, 10 and 11 select low-level detection on ticks of clk/DIV1, clk/DIV2 and clk/DIV3 (8, 16 and 128 by default). The flag sets after LOW_RUN (16) consecutive low samples. It is still 0 after 14 tick periods of low and is set after 19 tick periods.
- R5: Reading the flag word (address 1) with a bit at 1 arms that bit. In edge mode, a following write of 0 to that bit clears the flag.
- R6: A write of 1 to a flag bit leaves the flag unchanged. A write of 0 that was not preceded by a read showing the bit as 1 (since the last flag-word write) also leaves the flag unchanged.
- R7: In level mode, an armed write of 0 clears the flag only after the pin has been sampled high at the selected tick rate. While the pin stays low, the write leaves the flag set.
- R8: A trigger in the same cycle as an accepted clear wins, so the flag stays set.
- R9: `hiz_req` is the OR of all flags. It stays high until every flag has been cleared.
- R10: Each flag is set and cleared independently. Activity on one pin or a clear of one bit leaves the other flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 = mode word, 1 = flag word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the same cycle as `bus_rd`, 0 otherwise |
| pin_n | input | NPIN | Asynchronous active-low disable-request pins |
| hiz_req | output | 1 | High-impedance request to the output drivers |

## Verification
The bench uses the defaults: NPIN = 3, DIV1/DIV2/DIV3 = 8/16/128 and LOW_RUN = 16. With three pins it can run one pin per tick rate at the same time and still check that the flags stay independent. The largest divider makes a full level trip about 2,000 cycles, which keeps the slowest prescaler path exercised within the run time. A DW of 16 leaves reserved mode bits on both sides of the fields so they can be checked to read zero.

// File: rtl/odr_pkg.sv
package odr_pkg;
  typedef enum logic [1:0] {
    TRIG_FALL   = 2'b00,
    TRIG_LOW_D1 = 2'b01,
    TRIG_LOW_D2 = 2'b10,
    TRIG_LOW_D3 = 2'b11
  } trig_mode_e;

  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_FLAG = 1'b1;
endpackage

// File: rtl/odr_prescaler.sv
module odr_prescaler #(
  parameter int DIV1 = 8,
  parameter int DIV2 = 16,
  parameter int DIV3 = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] tick
);
  localparam int CW = $clog2(DIV3);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  // one strobe per divider: low bits of the shared counter all ones
  for (genvar k = 0; k < 3; k++) begin : g_tick
    localparam int LW = (k == 0) ? $clog2(DIV1) :
                        (k == 1) ? $clog2(DIV2) : $clog2(DIV3);
    assign tick[k] = &cnt_q[LW-1:0];
  end
endmodule

// File: rtl/odr_pin_detect.sv
module odr_pin_detect
  import odr_pkg::*;
#(
  parameter int LOW_RUN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_async_n,
  input  logic [1:0] mode,
  input  logic [2:0] tick,
  output logic       trig,
  output logic       hi_sample,
  output logic       level_mode
);
  localparam int RW = $clog2(LOW_RUN + 1);

  logic          s1_q, s2_q, prev_q;
  logic [RW-1:0] run_q;
  logic          sel_tick;
  logic          fall;

  // two-flop synchroniser plus history bit; idle level is high
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= pin_async_n;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_comb begin
    case (trig_mode_e'(mode))
      TRIG_LOW_D1: sel_tick = tick[0];
      TRIG_LOW_D2: sel_tick = tick[1];
      TRIG_LOW_D3: sel_tick = tick[2];
      default:     sel_tick = 1'b0;
    endcase
  end

  assign level_mode = (trig_mode_e'(mode) != TRIG_FALL);
  assign fall       = prev_q & ~s2_q;

  // consecutive-low counter, saturating at LOW_RUN
  always_ff @(posedge clk) begin
    if (!rst_n || !level_mode) begin
      run_q <= '0;
    end else if (sel_tick) begin
      if (s2_q)                      run_q <= '0;
      else if (run_q != RW'(LOW_RUN)) run_q <= run_q + 1'b1;
    end
  end

  assign trig      = level_mode ? (run_q == RW'(LOW_RUN)) : fall;
  assign hi_sample = level_mode & sel_tick & s2_q;
endmodule

// File: rtl/odr_flag_cell.sv
module odr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic level_mode,
  input  logic hi_sample,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic flag,
  output logic high_seen
);
  logic armed_q;
  logic clr_ok;

  // a read that returns 1 arms the bit; any flag-word write disarms it
  always_ff @(posedge clk) begin
    if (!rst_n)                armed_q <= 1'b0;
    else if (wr_hit)           armed_q <= 1'b0;
    else if (rd_hit && flag)   armed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || trig)   high_seen <= 1'b0;
    else if (!flag)       high_seen <= 1'b0;
    else if (hi_sample)   high_seen <= 1'b1;
  end

  assign clr_ok = wr_hit & ~wr_bit & armed_q & (~level_mode | high_seen);

  // a fresh trigger beats a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (trig)   flag <= 1'b1;
    else if (clr_ok) flag <= 1'b0;
  end
endmodule

// File: rtl/odr_unit.sv
module odr_unit
  import odr_pkg::*;
#(
  parameter int NPIN    = 3,
  parameter int DW      = 16,
  parameter int DIV1    = 8,
  parameter int DIV2    = 16,
  parameter int DIV3    = 128,
  parameter int LOW_RUN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pin_n,
  output logic            hiz_req
);
  localparam int FIELD_LSB = 2;

  logic [1:0]      mode_q [NPIN];
  logic [2:0]      tick;
  logic [NPIN-1:0] flag_q;
  logic [NPIN-1:0] trig_w;
  logic [NPIN-1:0] hi_w;
  logic [NPIN-1:0] lvl_w;
  logic [NPIN-1:0] seen_w;
  logic [DW-1:0]   mode_word;
  logic            mode_wr, flag_wr, flag_rd;

  assign mode_wr = bus_wr & (bus_addr == ADDR_MODE);
  assign flag_wr = bus_wr & (bus_addr == ADDR_FLAG);
  assign flag_rd = bus_rd & (bus_addr == ADDR_FLAG);

  odr_prescaler #(.DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_pre (
    .clk (clk),
    .rst_n (rst_n),
    .tick (tick)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n)       mode_q[i] <= TRIG_FALL;
      else if (mode_wr) mode_q[i] <= bus_wdata[FIELD_LSB + 2*i +: 2];
    end

    odr_pin_detect #(.LOW_RUN(LOW_RUN)) u_det (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_async_n (pin_n[i]),
      .mode        (mode_q[i]),
      .tick        (tick),
      .trig        (trig_w[i]),
      .hi_sample   (hi_w[i]),
      .level_mode  (lvl_w[i])
    );

    odr_flag_cell u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig       (trig_w[i]),
      .level_mode (lvl_w[i]),
      .hi_sample  (hi_w[i]),
      .rd_hit     (flag_rd),
      .wr_hit     (flag_wr),
      .wr_bit     (bus_wdata[i]),
      .flag       (flag_q[i]),
      .high_seen  (seen_w[i])
    );
  end

  always_comb begin
    mode_word = '0;
    for (int i = 0; i < NPIN; i++) mode_word[FIELD_LSB + 2*i +: 2] = mode_q[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_FLAG) bus_rdata[NPIN-1:0] = flag_q;
      else                       bus_rdata = mode_word;
    end
  end

  assign hiz_req = |flag_q;
endmodule

// File: rtl/odr_unit_chk.sv
module odr_unit_chk #(
  parameter int NPIN = 3,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_addr,
  input logic            bus_wr,
  input logic [DW-1:0]   bus_wdata,
  input logic [NPIN-1:0] flags,
  input logic [NPIN-1:0] trig,
  input logic [NPIN-1:0] lvl,
  input logic [NPIN-1:0] seen,
  input logic            hiz_req
);
  for (genvar i = 0; i < NPIN; i++) begin : g_p
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trig[i] |=> flags[i]);

    p_clear_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(bus_wr && bus_addr && !bus_wdata[i]));

    p_level_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(flags[i]) && $past(lvl[i])) |-> $past(seen[i]));
  end

  p_hiz_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hiz_req) |-> $past(bus_wr && bus_addr));

  p_hiz_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hiz_req) |-> $past(|trig));
endmodule

bind odr_unit odr_unit_chk #(.NPIN(NPIN), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .flags     (flag_q),
  .trig      (trig_w),
  .lvl       (lvl_w),
  .seen      (seen_w),
  .hiz_req   (hiz_req)
);

// File: tb/sim_odr_unit.sv
module sim_odr_unit;
  localparam int CLK_P = 10;
  localparam int NPIN  = 3;
  localparam int DW    = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_addr = 1'b0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic [NPIN-1:0] pin_n = '1;
  logic            hiz_req;

  int n_chk = 0;
  int n_bad = 0;

  odr_unit #(.NPIN(NPIN), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_n(pin_n), .hiz_req(hiz_req)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [DW-1:0] mode_word(input logic [1:0] m0, input logic [1:0] m1,
                                              input logic [1:0] m2);
    logic [DW-1:0] w;
    w = '0;
    w[3:2] = m0;
    w[5:4] = m1;
    w[7:6] = m2;
    return w;
  endfunction

  function automatic logic exp_hiz(input logic [NPIN-1:0] f);
    return |f;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    logic [NPIN-1:0] mask;
    void'($urandom(32'h5eed_0d1e));
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    bus_read(1'b1, rd);
    check(rd == '0, "R1 flags", rd, 0);
    bus_read(1'b0, rd);
    check(rd == '0, "R1 mode", rd, 0);
    check(hiz_req == 1'b0, "R1 hiz", hiz_req, 0);

    // R2 mode word layout
    bus_write(1'b0, '1);
    bus_read(1'b0, rd);
    check(rd == 16'h00FC, "R2 reserved bits", rd, 16'h00FC);
    bus_write(1'b0, mode_word(2'b01, 2'b10, 2'b11));
    bus_read(1'b0, rd);
    check(rd == mode_word(2'b01, 2'b10, 2'b11), "R2 readback", rd, mode_word(2'b01, 2'b10, 2'b11));
    bus_write(1'b0, '0);

    // R3/R5/R9 random edge pulses
    for (int it = 0; it < 20; it++) begin
      mask = NPIN'($urandom_range(0, 7));
      for (int i = 0; i < NPIN; i++) begin
        if (mask[i]) begin
          @(negedge clk); pin_n[i] = 1'b0;
          wait_cyc($urandom_range(1, 4));
          pin_n[i] = 1'b1;
        end
      end
      wait_cyc(5);
      check(hiz_req == exp_hiz(mask), "R9 hiz OR", hiz_req, exp_hiz(mask));
      bus_read(1'b1, rd);
      check(rd[NPIN-1:0] == mask, "R3 edge flags", rd, mask);
      bus_write(1'b1, '0);
      bus_read(1'b1, rd);
      check(rd == '0, "R5 handshake clear", rd, 0);
    end

    // R6 refused clears, then R5 accepted clear
    @(negedge clk); pin_n[0] = 1'b0; wait_cyc(2); pin_n[0] = 1'b1; wait_cyc(4);
    bus_read(1'b1, rd);
    bus_write(1'b1, 16'h0001);
    bus_read(1'b0, rd);
    bus_write(1'b1, '0);
    check(hiz_req == 1'b1, "R6 write0 without read", hiz_req, 1);
    bus_read(1'b1, rd);
    check(rd[0] == 1'b1, "R6 flag kept", rd, 1);
    bus_write(1'b1, '0);
    check(hiz_req == 1'b0, "R5 clear after read", hiz_req, 0);

    // R8 trigger in the same cycle as an accepted clear
    @(negedge clk); pin_n[1] = 1'b0; wait_cyc(2); pin_n[1] = 1'b1; wait_cyc(4);
    bus_read(1'b1, rd);
    check(rd[1] == 1'b1, "R8 setup", rd, 2);
    pin_n[1] = 1'b0;
    @(negedge clk);
    bus_write(1'b1, '0);
    pin_n[1] = 1'b1;
    bus_read(1'b1, rd);
    check(rd[1] == 1'b1, "R8 set wins", rd, 2);
    bus_write(1'b1, '0);
    check(hiz_req == 1'b0, "R8 cleanup", hiz_req, 0);

    // R4 level modes: pin0 div16, pin1 div128, pin2 div8
    bus_write(1'b0, mode_word(2'b10, 2'b11, 2'b01));
    wait_cyc(2);
    pin_n = '0;
    wait_cyc(8 * 14);
    bus_read(1'b1, rd);
    check(rd[2] == 1'b0, "R4 div8 early", rd, 0);
    wait_cyc(8 * 5);
    bus_read(1'b1, rd);
    check(rd[2] == 1'b1, "R4 div8 set", rd, 4);
    check(rd[0] == 1'b0, "R10 div16 still clear", rd, 4);
    wait_cyc(16 * 14 - 8 * 19 - 4);
    bus_read(1'b1, rd);
    check(rd[0] == 1'b0, "R4 div16 early", rd, 4);
    wait_cyc(16 * 5);
    bus_read(1'b1, rd);
    check(rd[1:0] == 2'b01, "R4 div16 set, div128 clear", rd, 5);

    // R7 level clear refused while low
    bus_write(1'b1, '0);
    bus_read(1'b1, rd);
    check(rd[2:0] == 3'b101, "R7 low pin blocks clear", rd, 5);

    wait_cyc(128 * 14 - 16 * 19 - 12);
    bus_read(1'b1, rd);
    check(rd[1] == 1'b0, "R4 div128 early", rd, 5);
    wait_cyc(128 * 5);
    bus_read(1'b1, rd);
    check(rd[2:0] == 3'b111, "R4 div128 set", rd, 7);

    // R7/R10 release pin2 only, clear only that flag
    pin_n[2] = 1'b1;
    wait_cyc(8 * 4);
    bus_read(1'b1, rd);
    bus_write(1'b1, '0);
    bus_read(1'b1, rd);
    check(rd[2:0] == 3'b011, "R10 only pin2 cleared", rd, 3);
    check(hiz_req == 1'b1, "R9 hiz held", hiz_req, 1);

    pin_n = '1;
    wait_cyc(128 * 4);
    bus_read(1'b1, rd);
    bus_write(1'b1, '0);
    bus_read(1'b1, rd);
    check(rd == '0, "R7 clear after high", rd, 0);
    check(hiz_req == 1'b0, "R9 hiz drops", hiz_req, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule